// File: doc/BRIEF.md
# Double-Buffered Synthesizer Programming Interface

This block is the control-register front end of an integer frequency synthesizer. It produces the main divider word, the swallow (accumulator) word, the reference divider word and an 8-bit enhancement word. Settings can be loaded three ways, picked by two mode inputs. In parallel mode, an 8-bit bus is written into the primary register in three sections, each with its own strobe. In serial mode, a 20-bit frame is shifted into the same primary register. In direct mode, dedicated pins drive the counter words with no register in between.

A hop strobe copies the whole primary register into a secondary register, so two frequencies can sit ready at once. A buffer-select input picks which copy feeds the counters. The select is sampled only on a reload pulse from the counter chain, so a switch lands at a counter boundary and no counter sees a half-changed word. This gives glitch-free ping-pong frequency hopping.

All strobes and the serial clock are sampled in the system clock domain. Their rising edges are found by comparing each one with its value in the previous cycle.

Top module: `synth_prog_if`

## Requirements
- R1: While `busMode` is 1 (direct mode), `cntM`, `cntR` and `cntA` follow `pinM`, `pinR` and `pinA` in the same cycle. Bits 8:7 of `cntM` and bits 5:4 of `cntR` are forced to 0, whatever the stored registers and `bufSel` hold.
- R2: In parallel mode (`busMode`=0, `serMode`=0), a rising edge on a write strobe loads its section of the primary register. `wrM1` loads M[7:0] from `dataBus[7:0]`. `wrM2` loads M[8] from `dataBus[7]` and R[5:0] from `dataBus[5:0]`; `dataBus[6]` is unused. `wrA` loads A[4:0] from `dataBus[4:0]`.
- R3: In either non-direct mode, a rising edge on `wrHop` copies the whole primary register into the secondary register on that clock edge.
- R4: The effective select resets to 0. It takes the value of `bufSel` only on a cycle where `reloadPulse` is 1 and holds at all other times. When the effective select is 1, the primary register drives the outputs; when it is 0, the secondary register does.
- R5: In parallel mode, a rising edge on `wrEnh` loads the enhancement register from `dataBus`. `enhWord` shows that register while `enhEnN` is 0 and shows 0 while `enhEnN` is 1.
- R6: In serial mode (`busMode`=0, `serMode`=1), each rising edge of `serClk` shifts `serData` into the primary register, but only while `wrEnh` and `wrSer` are both 0. A 20-bit frame is sent in the order M[8] down to M[0], then R[5] down to R[0], then A[4] down to A[0].
- R7: In serial mode, a rising edge on `wrSer` also copies the primary register into the secondary register.
- R8: Reset clears the primary, secondary and enhancement registers, so all counter outputs and `enhWord` read 0.
- R9: Serial-clock edges while `wrSer` is 1 are ignored. Section write strobes are ignored outside parallel mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busMode | input | 1 | 1 selects direct mode |
| serMode | input | 1 | With busMode=0: 1 serial, 0 parallel |
| dataBus | input | 8 | Parallel write data |
| wrM1 | input | 1 | Strobe for main word low section |
| wrM2 | input | 1 | Strobe for main MSB and reference section |
| wrA | input | 1 | Strobe for swallow section |
| wrEnh | input | 1 | Enhancement register strobe |
| wrSer | input | 1 | Serial write strobe / serial transfer |
| wrHop | input | 1 | Primary-to-secondary transfer strobe |
| serClk | input | 1 | Serial shift clock (sampled) |
| serData | input | 1 | Serial data |
| bufSel | input | 1 | Requested buffer: 1 primary, 0 secondary |
| reloadPulse | input | 1 | One-cycle counter reload indication |
| enhEnN | input | 1 | Active-low enhancement enable |
| pinM | input | 9 | Direct-mode main word |
| pinA | input | 5 | Direct-mode swallow word |
| pinR | input | 6 | Direct-mode reference word |
| cntM | output | 9 | Main divider word |
| cntA | output | 5 | Swallow word |
| cntR | output | 6 | Reference divider word |
| enhWord | output | 8 | Gated enhancement bits |

## Verification
The hardest case to reach is a state where the two buffers hold different values and `bufSel` has changed but no reload has happened yet. In that state the output must still show the old buffer. To reach it, the stimulus first hops a known word into the secondary register. It then rewrites a primary section without a hop and changes `bufSel` with no reload pulse, checks the outputs, and only then issues the reload. A second hard case is the serial path with `wrSer` held high. The bench sends clock edges in that state and then hops. If any of those bits had been taken, the secondary value would reveal it.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int M_W     = 9;
  localparam int R_W     = 6;
  localparam int A_W     = 5;
  localparam int BUS_W   = 8;
  localparam int ENH_W   = 8;
  localparam int FRAME_W = M_W + R_W + A_W;
  // bits kept in direct mode (upper bits forced low)
  localparam int DIR_M_KEEP = 7;
  localparam int DIR_R_KEEP = 4;
  localparam int EDGE_N     = 7;

  typedef enum logic [1:0] {
    MODE_PAR = 2'd0,
    MODE_SER = 2'd1,
    MODE_DIR = 2'd2
  } mode_e;

  // field order matches serial shift order (first bit lands in m MSB)
  typedef struct packed {
    logic [M_W-1:0] m;
    logic [R_W-1:0] r;
    logic [A_W-1:0] a;
  } frame_t;

  typedef struct packed {
    logic ldLow;
    logic ldHigh;
    logic ldAcc;
    logic shift;
    logic xfer;
    logic enhLoad;
    logic selLoad;
  } strobe_t;
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    busMode,
  input  logic    serMode,
  input  logic    wrM1,
  input  logic    wrM2,
  input  logic    wrA,
  input  logic    wrEnh,
  input  logic    wrSer,
  input  logic    wrHop,
  input  logic    serClk,
  input  logic    reloadPulse,
  output mode_e   mode,
  output strobe_t stb
);
  localparam int IDX_M1  = 0;
  localparam int IDX_M2  = 1;
  localparam int IDX_A   = 2;
  localparam int IDX_ENH = 3;
  localparam int IDX_SER = 4;
  localparam int IDX_HOP = 5;
  localparam int IDX_CLK = 6;

  logic [EDGE_N-1:0] edgeIn;
  logic [EDGE_N-1:0] edgePrev;
  logic [EDGE_N-1:0] rise;

  assign edgeIn = {serClk, wrHop, wrSer, wrEnh, wrA, wrM2, wrM1};

  for (genvar g = 0; g < EDGE_N; g++) begin : g_edge
    always_ff @(posedge clk) begin
      if (!rstN) edgePrev[g] <= 1'b0;
      else       edgePrev[g] <= edgeIn[g];
    end
    assign rise[g] = edgeIn[g] & ~edgePrev[g];
  end

  always_comb begin
    if (busMode)      mode = MODE_DIR;
    else if (serMode) mode = MODE_SER;
    else              mode = MODE_PAR;
  end

  logic isPar;
  logic isSer;
  assign isPar = (mode == MODE_PAR);
  assign isSer = (mode == MODE_SER);

  always_comb begin
    stb         = '0;
    stb.ldLow   = isPar & rise[IDX_M1];
    stb.ldHigh  = isPar & rise[IDX_M2];
    stb.ldAcc   = isPar & rise[IDX_A];
    stb.enhLoad = isPar & rise[IDX_ENH];
    stb.shift   = isSer & rise[IDX_CLK] & ~wrEnh & ~wrSer;
    stb.xfer    = (isPar & rise[IDX_HOP]) |
                  (isSer & (rise[IDX_HOP] | rise[IDX_SER]));
    stb.selLoad = reloadPulse;
  end
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  mode_e            mode,
  input  strobe_t          stb,
  input  logic [BUS_W-1:0] dataBus,
  input  logic             serData,
  input  logic             bufSel,
  input  logic             enhEnN,
  input  logic [M_W-1:0]   pinM,
  input  logic [A_W-1:0]   pinA,
  input  logic [R_W-1:0]   pinR,
  output logic [M_W-1:0]   cntM,
  output logic [A_W-1:0]   cntA,
  output logic [R_W-1:0]   cntR,
  output logic [ENH_W-1:0] enhWord,
  output frame_t           primQ,
  output frame_t           secQ,
  output logic             selQ
);
  localparam int LOW_W = BUS_W;
  localparam int M_HI  = M_W - LOW_W;

  frame_t           primReg;
  frame_t           secReg;
  logic [ENH_W-1:0] enhReg;
  logic             selEff;

  // primary register: section writes or serial shift
  always_ff @(posedge clk) begin
    if (!rstN) begin
      primReg <= '0;
    end else if (stb.shift) begin
      primReg <= frame_t'({primReg[FRAME_W-2:0], serData});
    end else begin
      if (stb.ldLow)  primReg.m[LOW_W-1:0] <= dataBus[LOW_W-1:0];
      if (stb.ldHigh) begin
        primReg.m[M_W-1 -: M_HI] <= dataBus[BUS_W-1 -: M_HI];
        primReg.r                <= dataBus[R_W-1:0];
      end
      if (stb.ldAcc)  primReg.a <= dataBus[A_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         secReg <= '0;
    else if (stb.xfer) secReg <= primReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            enhReg <= '0;
    else if (stb.enhLoad) enhReg <= dataBus[ENH_W-1:0];
  end

  // buffer select applied only at counter reload
  always_ff @(posedge clk) begin
    if (!rstN)            selEff <= 1'b0;
    else if (stb.selLoad) selEff <= bufSel;
  end

  frame_t chosen;
  assign chosen = selEff ? primReg : secReg;

  always_comb begin
    if (mode == MODE_DIR) begin
      cntM = {{(M_W-DIR_M_KEEP){1'b0}}, pinM[DIR_M_KEEP-1:0]};
      cntR = {{(R_W-DIR_R_KEEP){1'b0}}, pinR[DIR_R_KEEP-1:0]};
      cntA = pinA;
    end else begin
      cntM = chosen.m;
      cntR = chosen.r;
      cntA = chosen.a;
    end
  end

  assign enhWord = enhEnN ? '0 : enhReg;
  assign primQ   = primReg;
  assign secQ    = secReg;
  assign selQ    = selEff;
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import sp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busMode,
  input  logic             serMode,
  input  logic [BUS_W-1:0] dataBus,
  input  logic             wrM1,
  input  logic             wrM2,
  input  logic             wrA,
  input  logic             wrEnh,
  input  logic             wrSer,
  input  logic             wrHop,
  input  logic             serClk,
  input  logic             serData,
  input  logic             bufSel,
  input  logic             reloadPulse,
  input  logic             enhEnN,
  input  logic [M_W-1:0]   pinM,
  input  logic [A_W-1:0]   pinA,
  input  logic [R_W-1:0]   pinR,
  output logic [M_W-1:0]   cntM,
  output logic [A_W-1:0]   cntA,
  output logic [R_W-1:0]   cntR,
  output logic [ENH_W-1:0] enhWord
);
  mode_e   mode;
  strobe_t stb;
  frame_t  primQ;
  frame_t  secQ;
  logic    selQ;

  sp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busMode(busMode), .serMode(serMode),
    .wrM1(wrM1), .wrM2(wrM2), .wrA(wrA), .wrEnh(wrEnh), .wrSer(wrSer),
    .wrHop(wrHop), .serClk(serClk), .reloadPulse(reloadPulse),
    .mode(mode), .stb(stb)
  );

  sp_datapath u_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .stb(stb), .dataBus(dataBus),
    .serData(serData), .bufSel(bufSel), .enhEnN(enhEnN),
    .pinM(pinM), .pinA(pinA), .pinR(pinR),
    .cntM(cntM), .cntA(cntA), .cntR(cntR), .enhWord(enhWord),
    .primQ(primQ), .secQ(secQ), .selQ(selQ)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker
  import sp_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             busMode,
  input logic             serMode,
  input logic             wrEnh,
  input logic             wrSer,
  input logic             wrHop,
  input logic             serClk,
  input logic             serData,
  input logic             reloadPulse,
  input logic             enhEnN,
  input logic [A_W-1:0]   pinA,
  input logic [M_W-1:0]   cntM,
  input logic [A_W-1:0]   cntA,
  input logic [R_W-1:0]   cntR,
  input logic [ENH_W-1:0] enhWord,
  input frame_t           primQ,
  input frame_t           secQ,
  input logic             selQ
);
  assert_direct_forced_R1: assert property (@(posedge clk) disable iff (!rstN)
    busMode |-> (cntM[M_W-1:DIR_M_KEEP] == '0 && cntR[R_W-1:DIR_R_KEEP] == '0
                 && cntA == pinA));

  assert_hop_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!busMode && wrHop && !$past(wrHop) && $past(rstN)) |=> (secQ == $past(primQ)));

  assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !reloadPulse |=> $stable(selQ));

  assert_enh_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    enhEnN |-> (enhWord == '0));

  assert_serial_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busMode && serMode && serClk && !$past(serClk) && $past(rstN)
     && !wrEnh && !wrSer) |=> (primQ.a[0] == $past(serData)));
endmodule

bind synth_prog_if sp_checker u_chk (
  .clk(clk), .rstN(rstN), .busMode(busMode), .serMode(serMode),
  .wrEnh(wrEnh), .wrSer(wrSer), .wrHop(wrHop), .serClk(serClk),
  .serData(serData), .reloadPulse(reloadPulse), .enhEnN(enhEnN),
  .pinA(pinA), .cntM(cntM), .cntA(cntA), .cntR(cntR), .enhWord(enhWord),
  .primQ(primQ), .secQ(secQ), .selQ(selQ)
);

// File: tb/synth_prog_if_bench.sv
module synth_prog_if_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busMode = 1'b0, serMode = 1'b0;
  logic [7:0] dataBus = '0;
  logic       wrM1 = 0, wrM2 = 0, wrA = 0, wrEnh = 0, wrSer = 0, wrHop = 0;
  logic       serClk = 0, serData = 0, bufSel = 0, reloadPulse = 0, enhEnN = 1;
  logic [8:0] pinM = '0;
  logic [4:0] pinA = '0;
  logic [5:0] pinR = '0;
  logic [8:0] cntM;
  logic [4:0] cntA;
  logic [5:0] cntR;
  logic [7:0] enhWord;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  synth_prog_if u_synth_prog_if (
    .clk(clk), .rstN(rstN), .busMode(busMode), .serMode(serMode),
    .dataBus(dataBus), .wrM1(wrM1), .wrM2(wrM2), .wrA(wrA), .wrEnh(wrEnh),
    .wrSer(wrSer), .wrHop(wrHop), .serClk(serClk), .serData(serData),
    .bufSel(bufSel), .reloadPulse(reloadPulse), .enhEnN(enhEnN),
    .pinM(pinM), .pinA(pinA), .pinR(pinR),
    .cntM(cntM), .cntA(cntA), .cntR(cntR), .enhWord(enhWord)
  );

  typedef struct packed {
    logic [7:0] m1;
    logic [7:0] m2;
    logic [7:0] a;
    logic [8:0] eM;
    logic [5:0] eR;
    logic [4:0] eA;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{m1: 8'h5A, m2: 8'h83, a: 8'hF7, eM: 9'h15A, eR: 6'h03, eA: 5'h17},
    '{m1: 8'h01, m2: 8'h3F, a: 8'h00, eM: 9'h001, eR: 6'h3F, eA: 5'h00},
    '{m1: 8'hFF, m2: 8'hC0, a: 8'h1F, eM: 9'h1FF, eR: 6'h00, eA: 5'h1F},
    '{m1: 8'h00, m2: 8'h40, a: 8'hE5, eM: 9'h000, eR: 6'h00, eA: 5'h05}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // 0:wrM1 1:wrM2 2:wrA 3:wrEnh 4:wrSer 5:wrHop
  task automatic strobe(input int which, input logic [7:0] d);
    @(negedge clk);
    dataBus = d;
    case (which)
      0: wrM1 = 1; 1: wrM2 = 1; 2: wrA = 1;
      3: wrEnh = 1; 4: wrSer = 1; default: wrHop = 1;
    endcase
    @(negedge clk);
    wrM1 = 0; wrM2 = 0; wrA = 0; wrEnh = 0; wrSer = 0; wrHop = 0;
  endtask

  task automatic reload();
    @(negedge clk); reloadPulse = 1;
    @(negedge clk); reloadPulse = 0;
  endtask

  task automatic shiftBit(input logic b);
    @(negedge clk); serData = b; serClk = 1;
    @(negedge clk); serClk = 0;
  endtask

  task automatic checkWords(input string tag, input logic [8:0] m,
                            input logic [5:0] r, input logic [4:0] a);
    check({tag, " M"}, 32'(cntM), 32'(m));
    check({tag, " R"}, 32'(cntR), 32'(r));
    check({tag, " A"}, 32'(cntA), 32'(a));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [19:0] frame;
    logic [8:0] lastM;
    logic [5:0] lastR;
    logic [4:0] lastA;
    repeat (3) @(negedge clk);
    rstN = 1;
    enhEnN = 0;
    @(negedge clk);
    // R8 reset state
    checkWords("R8 reset", 9'h0, 6'h0, 5'h0);
    check("R8 reset enh", 32'(enhWord), 32'h0);

    // R2/R3/R4 vector walk, secondary selected
    lastM = '0; lastR = '0; lastA = '0;
    for (int i = 0; i < 4; i++) begin
      strobe(0, VECS[i].m1);
      strobe(1, VECS[i].m2);
      strobe(2, VECS[i].a);
      checkWords("R4 secondary held before hop", lastM, lastR, lastA);
      strobe(5, 8'h00);
      checkWords("R2 R3 after hop", VECS[i].eM, VECS[i].eR, VECS[i].eA);
      lastM = VECS[i].eM; lastR = VECS[i].eR; lastA = VECS[i].eA;
    end

    // R4 select only on reload
    strobe(0, 8'h77);
    bufSel = 1;
    repeat (2) @(negedge clk);
    checkWords("R4 select without reload", 9'h000, 6'h00, 5'h05);
    reload();
    checkWords("R4 primary after reload", 9'h077, 6'h00, 5'h05);
    bufSel = 0;
    repeat (2) @(negedge clk);
    check("R4 hold primary", 32'(cntM), 32'h077);
    reload();
    check("R4 back to secondary", 32'(cntM), 32'h000);

    // R5 enhancement register and enable
    enhEnN = 1;
    strobe(3, 8'hA5);
    check("R5 disabled enh", 32'(enhWord), 32'h0);
    enhEnN = 0;
    @(negedge clk);
    check("R5 enabled enh", 32'(enhWord), 32'hA5);

    // R6/R7 serial frame
    serMode = 1;
    frame = {9'h0AB, 6'h2C, 5'h13};
    for (int b = 19; b >= 0; b--) shiftBit(frame[b]);
    checkWords("R6 secondary unchanged before transfer", 9'h000, 6'h00, 5'h05);
    strobe(4, 8'h00);
    checkWords("R6 R7 serial transfer", 9'h0AB, 6'h2C, 5'h13);

    // R9 serial clock ignored while wrSer high; section strobes ignored
    @(negedge clk); wrSer = 1; serData = 1;
    @(negedge clk); serClk = 1;
    @(negedge clk); serClk = 0;
    @(negedge clk); wrSer = 0;
    strobe(0, 8'h00);
    strobe(2, 8'h00);
    strobe(5, 8'h00);
    checkWords("R9 ignored edges", 9'h0AB, 6'h2C, 5'h13);

    // R1 direct mode
    busMode = 1;
    pinM = 9'h1FF; pinR = 6'h3F; pinA = 5'h0A;
    bufSel = 1;
    reload();
    checkWords("R1 direct forced", 9'h07F, 6'h0F, 5'h0A);
    pinM = 9'h055; pinR = 6'h05; pinA = 5'h11;
    @(negedge clk);
    checkWords("R1 direct follows pins", 9'h055, 6'h05, 5'h11);

    // R9 parallel strobes ignored in direct mode
    strobe(0, 8'hEE);
    busMode = 0; serMode = 0;
    @(negedge clk);
    checkWords("R9 direct write ignored", 9'h0AB, 6'h2C, 5'h13);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule